// File: doc/BRIEF.md
# Peripheral interrupt priority controller

This block holds the priority levels of twenty interrupt sources in five 16-bit registers. Each register has four 4-bit level fields. A source is an on-chip peripheral or one of six external request lines. Software reads and writes the registers over a plain register bus. Each cycle, the block also picks the pending source with the highest nonzero level. It reports that source's ID and level, and raises a request flag when the level is above the CPU's current mask.

Source IDs run from 0 to 19. The ID of a source is `4*register + slot`. Slot 0 is bits 15:12 and slot 3 is bits 3:0.

| Register | Slot 0 | Slot 1 | Slot 2 | Slot 3 |
|----------|--------|--------|--------|--------|
| 0 | timer ch0 (ID 0) | timer ch1 (ID 1) | timer ch2 (ID 2) | real-time clock (ID 3) |
| 1 | watchdog (ID 4) | refresh controller (ID 5) | serial port (ID 6) | reserved (ID 7) |
| 2 | IRQ3 (ID 8) | IRQ2 (ID 9) | IRQ1 (ID 10) | IRQ0 (ID 11) |
| 3 | reserved (ID 12) | reserved (ID 13) | IRQ5 (ID 14) | IRQ4 (ID 15) |
| 4 | DMA controller (ID 16) | reserved (ID 17) | FIFO serial port (ID 18) | ADC (ID 19) |

The block does not fetch vectors, update the CPU mask, detect edges on the request pins or handle the non-maskable interrupt.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Registers 0 to 4 sit at addresses 0 to 4. A write with `wr_en` high loads `wdata` on the clock edge. `rdata` shows the register selected by `addr` in the same cycle, with no register stage.
- R2: The reserved fields always read as zero and ignore written data. These are register 1 bits 3:0, register 3 bits 15:8 and register 4 bits 11:8 (source IDs 7, 12, 13 and 17).
- R3: Addresses 5 to 7 read as zero, and writes to them change no register.
- R4: Three events clear all five registers to zero: `rst_n` low (power-on reset, asynchronous), `man_rst` high at a clock edge, and `hw_stby` high at a clock edge.
- R5: While `stby` (ordinary standby) is high, the registers keep their contents and bus writes are ignored.
- R6: A source whose level field is 0 never wins the resolution, even while its request is high.
- R7: Among pending sources (`req[ID]` high), the source with the highest level drives `irq_id` and `irq_lvl`. Source ID `n` is request bit `n`.
- R8: When pending sources tie at the highest level, the lowest source ID wins.
- R9: `irq_valid` is high only when the winning level is strictly greater than `cpu_mask`. When no source qualifies, `irq_id` and `irq_lvl` read 0.
- R10: The resolver is combinational over the registers and `req`. A level written at an edge affects `irq_*` from the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| hw_stby | input | 1 | Hardware standby, clears registers |
| stby | input | 1 | Ordinary standby, freezes registers |
| addr | input | 3 | Register select |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| req | input | 20 | Pending request per source ID |
| cpu_mask | input | 4 | Current CPU mask level |
| irq_valid | output | 1 | Winning level exceeds the mask |
| irq_id | output | 5 | Winning source ID |
| irq_lvl | output | 4 | Winning level |

## Verification
A register write and a resolution can happen in the same cycle, and the write may change the level of the source that is winning at that moment. The randomized phase drives writes, request vectors and mask values together on the same cycle. It also mixes in standby and the two clear events, so that some writes collide with a freeze or a clear. In each cycle the outputs are compared with a bench model that still holds the pre-edge levels. The write is applied to the model only after the edge, so a design that lets a write reach the resolver too early, or lets it slip through a freeze or a clear, disagrees with the model.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_REGS  = 5,
  parameter int SLOTS     = 4,
  parameter int LVL_W     = 4,
  parameter int ADDR_W    = 3,
  parameter logic [NUM_REGS*SLOTS-1:0] RSVD_MASK = 20'h23080,
  localparam int REG_W    = SLOTS * LVL_W,
  localparam int NSRC     = NUM_REGS * SLOTS,
  localparam int ID_W     = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              man_rst,
  input  logic              hw_stby,
  input  logic              stby,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [NSRC-1:0]   req,
  input  logic [LVL_W-1:0]  cpu_mask,
  output logic              irq_valid,
  output logic [ID_W-1:0]   irq_id,
  output logic [LVL_W-1:0]  irq_lvl
);

  function automatic logic [REG_W-1:0] keep_bits(int r);
    logic [REG_W-1:0] k;
    for (int f = 0; f < SLOTS; f++)
      k[REG_W-1-f*LVL_W -: LVL_W] = RSVD_MASK[r*SLOTS+f] ? '0 : '1;
    return k;
  endfunction

  function automatic logic [NUM_REGS-1:0][REG_W-1:0] rsvd_all();
    logic [NUM_REGS-1:0][REG_W-1:0] v;
    for (int r = 0; r < NUM_REGS; r++) v[r] = ~keep_bits(r);
    return v;
  endfunction

  localparam logic [NUM_REGS-1:0][REG_W-1:0] RSVD_BITS = rsvd_all();

  logic [NUM_REGS-1:0][REG_W-1:0] prio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio_q <= '0;
    else if (man_rst || hw_stby) prio_q <= '0;
    else if (wr_en && !stby) begin
      for (int r = 0; r < NUM_REGS; r++)
        if (addr == ADDR_W'(r)) prio_q[r] <= wdata & keep_bits(r);
    end
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (addr == ADDR_W'(r)) rdata = prio_q[r];
  end

  logic [LVL_W-1:0] best_lvl;
  logic [ID_W-1:0]  best_id;

  always_comb begin
    best_lvl = '0;
    best_id  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && prio_q[i/SLOTS][REG_W-1-(i%SLOTS)*LVL_W -: LVL_W] > best_lvl) begin
        best_lvl = prio_q[i/SLOTS][REG_W-1-(i%SLOTS)*LVL_W -: LVL_W];
        best_id  = ID_W'(i);
      end
    end
  end

  assign irq_lvl   = best_lvl;
  assign irq_id    = best_id;
  assign irq_valid = best_lvl > cpu_mask;

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_q & RSVD_BITS) == '0);

  assert_hi_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) >= NUM_REGS) |-> rdata == '0);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (man_rst || hw_stby) |=> prio_q == '0);

  assert_hold_stby_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stby && !man_rst && !hw_stby) |=> $stable(prio_q));

  assert_winner_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> req[irq_id]);

  assert_above_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_lvl > cpu_mask && irq_lvl != '0));

endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  logic clk = 0, rst_n = 0, man_rst = 0, hw_stby = 0, stby = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [19:0] req = 0;
  logic [3:0] cpu_mask = 0, irq_lvl;
  logic [4:0] irq_id;
  logic irq_valid;
  int tests = 0, fails = 0;
  logic [15:0] mdl [5];

  always #5 clk = ~clk;

  irq_prio_ctrl dut_i (.clk, .rst_n, .man_rst, .hw_stby, .stby, .addr, .wr_en,
    .wdata, .rdata, .req, .cpu_mask, .irq_valid, .irq_id, .irq_lvl);

  function automatic logic [15:0] keep(int r);
    case (r)
      1: return 16'hFFF0;
      3: return 16'h00FF;
      4: return 16'hF0FF;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [15:0] exp_rd(logic [2:0] a);
    return (a < 5) ? mdl[a] : 16'h0;
  endfunction

  function automatic logic [3:0] lvl_of(int i);
    return mdl[i/4][15-4*(i%4) -: 4];
  endfunction

  function automatic logic [8:0] exp_win();
    logic [3:0] b = 0; logic [4:0] id = 0;
    for (int i = 0; i < 20; i++)
      if (req[i] && lvl_of(i) > b) begin b = lvl_of(i); id = 5'(i); end
    return {id, b};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic chk_all(string tag);
    logic [8:0] w = exp_win();
    #1;
    chk({tag, " rdata R1"}, 32'(rdata), 32'(exp_rd(addr)));
    chk({tag, " id R7 R8"}, 32'(irq_id), 32'(w[8:4]));
    chk({tag, " lvl R6 R7"}, 32'(irq_lvl), 32'(w[3:0]));
    chk({tag, " valid R9"}, 32'(irq_valid), 32'(w[3:0] > cpu_mask));
  endtask

  task automatic step();
    @(posedge clk);
    if (man_rst || hw_stby) for (int r = 0; r < 5; r++) mdl[r] = 0;
    else if (wr_en && !stby && addr < 5) mdl[addr] = wdata & keep(int'(addr));
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1; step(); wr_en = 0;
  endtask

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7731));
    for (int r = 0; r < 5; r++) mdl[r] = 0;
    repeat (3) @(negedge clk);
    req = '1; cpu_mask = 0;
    for (int a = 0; a < 5; a++) begin addr = 3'(a); #1 chk("reset clear R4", 32'(rdata), 0); end
    chk("reset idle R9", 32'(irq_valid), 0);
    rst_n = 1; req = 0;
    @(negedge clk);
    for (int a = 0; a < 8; a++) wr(3'(a), 16'hFFFF);
    addr = 1; #1 chk("rsvd reg1 R2", 32'(rdata), 32'h0000FFF0);
    addr = 3; #1 chk("rsvd reg3 R2", 32'(rdata), 32'h000000FF);
    addr = 4; #1 chk("rsvd reg4 R2", 32'(rdata), 32'h0000F0FF);
    addr = 6; #1 chk("high addr R3", 32'(rdata), 0);
    req = 20'h23080; chk_all("reserved never win R6");
    chk("rsvd no valid R6", 32'(irq_valid), 0);
    for (int a = 0; a < 5; a++) wr(3'(a), 16'h0);
    wr(3'd2, 16'h5500);
    req = 20'h00300; cpu_mask = 4; #1;
    chk("tie low id R8", 32'(irq_id), 8);
    chk("tie lvl R8", 32'(irq_lvl), 5);
    cpu_mask = 5; #1 chk("mask equal R9", 32'(irq_valid), 0);
    cpu_mask = 0;
    addr = 0; wdata = 16'h0009; wr_en = 1; req = 20'h00308; #1;
    chk("pre-edge lvl R10", 32'(irq_lvl), 5);
    step(); wr_en = 0; #1;
    chk("post-edge id R10", 32'(irq_id), 3);
    chk("post-edge lvl R10", 32'(irq_lvl), 9);
    stby = 1; wr(3'd0, 16'h1111); stby = 0;
    addr = 0; #1 chk("stby hold R5", 32'(rdata), 32'h0009);
    hw_stby = 1; step(); hw_stby = 0; addr = 2; #1 chk("hw stby clear R4", 32'(rdata), 0);
    wr(3'd2, 16'h1234); man_rst = 1; step(); man_rst = 0; #1 chk("manual clear R4", 32'(rdata), 0);
    for (int n = 0; n < 3000; n++) begin
      addr = 3'($urandom_range(7)); wdata = 16'($urandom);
      wr_en = ($urandom_range(3) != 0); req = 20'($urandom);
      cpu_mask = 4'($urandom_range(6));
      stby = ($urandom_range(9) == 0); man_rst = ($urandom_range(49) == 0);
      hw_stby = ($urandom_range(49) == 0);
      chk_all("random");
      step();
    end
    man_rst = 0; hw_stby = 0; stby = 0; wr_en = 0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule